// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries. Each entry holds a VLAN ID, a member port mask and a valid flag. Software does not write the entries directly. It puts a member mask in a data register and then writes a command word that carries an opcode, a port number, a VLAN ID and a go bit. The go bit reads back as a busy flag until the engine has finished. The engine can invalidate the whole table, load or overwrite one entry, invalidate one entry by VLAN ID, or remove one port from every entry.

A separate lookup port serves an external forwarding path. It takes a VLAN ID and returns a hit flag and the member mask of the matching valid entry in the same cycle, with no register on the path. Loads never create two valid entries with the same VLAN ID, so at most one entry can match.

Top module: `vtab_engine`

## Requirements
- R1: After reset the busy and full flags are 0, both registers read back 0, and every lookup misses (hit 0, mask 0).
- R2: The command register (reg_addr 0) reads back the opcode in bits 2:0, busy in bit 3, full in bit 4, the port number in bits 11:8 and the VLAN ID in bits 27:16, with all other bits 0. A write with bit 3 clear stores the fields and starts nothing.
- R3: A write with bit 3 set starts the operation. For opcode 2 (load), 3 (purge), 0 (no-op) and the unused codes 5 to 7, busy reads 1 for exactly one cycle after the write and then 0.
- R4: Opcode 1 (flush) invalidates every entry, one entry per cycle. Busy stays 1 for exactly NUM_ENTRIES cycles after the write, and every lookup misses afterwards.
- R5: A load of a VLAN ID that is not in the table fills the lowest-numbered invalid entry. The entry takes the mask from data register bits 9:0 and becomes valid whatever data bit 11 holds.
- R6: A load of a VLAN ID that is already valid replaces that entry's mask. No second entry is created.
- R7: A load of a new VLAN ID when no invalid entry is left sets the full flag and changes no entry. The next command started with bit 3 set clears the full flag.
- R8: Purge (opcode 3) invalidates the valid entry whose VLAN ID matches. If none matches, the table is unchanged.
- R9: Remove-port (opcode 4) clears bit <port> of the mask in every entry, one entry per cycle. Busy stays 1 for NUM_ENTRIES cycles and the entries stay valid. A port number at or above NUM_PORTS changes nothing.
- R10: While busy is 1, writes to the command register and to the data register are ignored. The started operation and the register contents are unaffected.
- R11: The lookup port gives hit 1 and the entry's mask in the same cycle as a VLAN ID that matches a valid entry. Otherwise it gives hit 0 and mask 0.
- R12: The data register (reg_addr 1) reads back the mask in bits 9:0 and the stored valid bit in bit 11, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select for read and write: 0 command, 1 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| lk_vid | input | 12 | VLAN ID presented for lookup |
| lk_hit | output | 1 | A valid entry matches lk_vid |
| lk_mask | output | 10 | Member mask of the matching entry, 0 on a miss |

## Verification
The assertions assume that reg_wr and reg_wdata are known at every clock edge after reset. They also assume the opcode field only selects among the listed operations, with unused codes behaving as a no-op, and that the lookup VLAN ID may change freely. The stimulus drives all inputs on the falling edge and polls busy through the command register before each new command. The one exception is the R10 test, which writes on purpose while busy is set. Every VLAN ID the bench loads is computed to be distinct, except where it repeats one on purpose to test the overwrite rule.

// File: rtl/vtab_pkg.sv
package vtab_pkg;

    // opcode values in command bits 2:0
    localparam logic [2:0] OPC_NOP   = 3'd0;
    localparam logic [2:0] OPC_FLUSH = 3'd1;
    localparam logic [2:0] OPC_LOAD  = 3'd2;
    localparam logic [2:0] OPC_PURGE = 3'd3;
    localparam logic [2:0] OPC_DROP  = 3'd4;

    // register select
    localparam logic ADDR_CMD  = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    // command word bit positions
    localparam int CMD_GO_BIT   = 3;
    localparam int CMD_FULL_BIT = 4;
    localparam int CMD_PORT_LSB = 8;
    localparam int CMD_PORT_W   = 4;
    localparam int CMD_VID_LSB  = 16;

    // data word bit positions
    localparam int DATA_VALID_BIT = 11;

    // table update requests from the sequencer to the store
    typedef enum logic [1:0] {
        SC_NONE  = 2'd0,
        SC_WRITE = 2'd1,
        SC_INVAL = 2'd2,
        SC_DROP  = 2'd3
    } scmd_e;

endpackage

// File: rtl/vtab_store.sv
module vtab_store
    import vtab_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 10,
    parameter int VID_W       = 12,
    localparam int IW         = $clog2(NUM_ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    // update request
    input  scmd_e                 s_cmd,
    input  logic [IW-1:0]         s_idx,
    input  logic [VID_W-1:0]      s_vid,
    input  logic [NUM_PORTS-1:0]  s_mask,
    input  logic [CMD_PORT_W-1:0] s_port,
    // search for the command VID
    input  logic [VID_W-1:0]      q_vid,
    output logic                  q_hit,
    output logic [IW-1:0]         q_hit_idx,
    output logic                  q_free,
    output logic [IW-1:0]         q_free_idx,
    output logic [NUM_ENTRIES-1:0] valid_vec,
    // forwarding lookup
    input  logic [VID_W-1:0]      lk_vid,
    output logic                  lk_hit,
    output logic [NUM_PORTS-1:0]  lk_mask
);

    typedef struct packed {
        logic                 valid;
        logic [VID_W-1:0]     vid;
        logic [NUM_PORTS-1:0] mask;
    } ent_t;

    ent_t tab_q [NUM_ENTRIES];
    ent_t tab_d [NUM_ENTRIES];

    logic [NUM_ENTRIES-1:0] lk_match;

    always_comb begin
        tab_d = tab_q;
        case (s_cmd)
            SC_WRITE: tab_d[s_idx] = '{valid: 1'b1, vid: s_vid, mask: s_mask};
            SC_INVAL: tab_d[s_idx].valid = 1'b0;
            SC_DROP:  tab_d[s_idx].mask  = tab_q[s_idx].mask &
                                           ~(NUM_PORTS'(1) << s_port);
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) tab_q[i] <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_ent
            assign valid_vec[g] = tab_q[g].valid;
            assign lk_match[g]  = tab_q[g].valid && (tab_q[g].vid == lk_vid);
        end
    endgenerate

    // lowest index wins for both searches
    always_comb begin
        q_hit      = 1'b0;
        q_hit_idx  = '0;
        q_free     = 1'b0;
        q_free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (tab_q[i].valid && (tab_q[i].vid == q_vid)) begin
                q_hit     = 1'b1;
                q_hit_idx = IW'(i);
            end
            if (!tab_q[i].valid) begin
                q_free     = 1'b1;
                q_free_idx = IW'(i);
            end
        end
    end

    always_comb begin
        lk_mask = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (lk_match[i]) lk_mask = lk_mask | tab_q[i].mask;
        end
    end
    assign lk_hit = |lk_match;

    AST_UNIQUE_VID: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R6

    AST_IDLE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cmd == SC_NONE) |=> $stable(valid_vec)); // R10

endmodule

// File: rtl/vtab_ctrl.sv
module vtab_ctrl
    import vtab_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 10,
    parameter int VID_W       = 12,
    localparam int IW         = $clog2(NUM_ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  addr,
    input  logic [31:0]           wr_data,
    output logic [31:0]           rd_data,
    // store interface
    output scmd_e                 s_cmd,
    output logic [IW-1:0]         s_idx,
    output logic [VID_W-1:0]      s_vid,
    output logic [NUM_PORTS-1:0]  s_mask,
    output logic [CMD_PORT_W-1:0] s_port,
    input  logic                  q_hit,
    input  logic [IW-1:0]         q_hit_idx,
    input  logic                  q_free,
    input  logic [IW-1:0]         q_free_idx,
    // state for checks at the top
    output logic                  busy_o,
    output logic [2:0]            op_o
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_ENTRIES - 1);

    typedef struct packed {
        logic                  busy;
        logic                  full;
        logic [2:0]            op;
        logic [CMD_PORT_W-1:0] port;
        logic [VID_W-1:0]      vid;
        logic [NUM_PORTS-1:0]  dmask;
        logic                  dvalid;
        logic [IW-1:0]         walk;
    } ctl_t;

    ctl_t q, d;
    logic unused_wbits;
    logic walking;

    assign unused_wbits = ^wr_data;
    assign walking = (q.op == OPC_FLUSH) || (q.op == OPC_DROP);

    always_comb begin
        d      = q;
        s_cmd  = SC_NONE;
        s_idx  = q.walk;
        s_vid  = q.vid;
        s_mask = q.dmask;
        s_port = q.port;
        if (!q.busy) begin
            if (wr_en && addr == ADDR_CMD) begin
                d.op   = wr_data[2:0];
                d.port = wr_data[CMD_PORT_LSB +: CMD_PORT_W];
                d.vid  = wr_data[CMD_VID_LSB +: VID_W];
                if (wr_data[CMD_GO_BIT]) begin
                    d.busy = 1'b1;
                    d.full = 1'b0;
                    d.walk = '0;
                end
            end
            if (wr_en && addr == ADDR_DATA) begin
                d.dmask  = wr_data[NUM_PORTS-1:0];
                d.dvalid = wr_data[DATA_VALID_BIT];
            end
        end else begin
            case (q.op)
                OPC_FLUSH: s_cmd = SC_INVAL;
                OPC_DROP:  s_cmd = SC_DROP;
                OPC_LOAD: begin
                    d.busy = 1'b0;
                    if (q_hit) begin
                        s_cmd = SC_WRITE;
                        s_idx = q_hit_idx;
                    end else if (q_free) begin
                        s_cmd = SC_WRITE;
                        s_idx = q_free_idx;
                    end else begin
                        d.full = 1'b1;
                    end
                end
                OPC_PURGE: begin
                    d.busy = 1'b0;
                    if (q_hit) begin
                        s_cmd = SC_INVAL;
                        s_idx = q_hit_idx;
                    end
                end
                default: d.busy = 1'b0;
            endcase
            if (walking) begin
                if (q.walk == LAST_IDX) d.busy = 1'b0;
                else                    d.walk = q.walk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_CMD) begin
            rd_data[2:0]                        = q.op;
            rd_data[CMD_GO_BIT]                 = q.busy;
            rd_data[CMD_FULL_BIT]               = q.full;
            rd_data[CMD_PORT_LSB +: CMD_PORT_W] = q.port;
            rd_data[CMD_VID_LSB +: VID_W]       = q.vid;
        end else begin
            rd_data[NUM_PORTS-1:0]  = q.dmask;
            rd_data[DATA_VALID_BIT] = q.dvalid;
        end
    end

    assign busy_o = q.busy;
    assign op_o   = q.op;

    AST_WALK_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && walking && q.walk != LAST_IDX) |=> q.busy); // R4

    AST_SHORT_OP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !walking) |=> !q.busy); // R3

    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> ($stable(q.op) && $stable(q.vid) && $stable(q.port)
                    && $stable(q.dmask) && $stable(q.dvalid))); // R10

    AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> ($past(q.op) == OPC_LOAD && s_cmd == SC_NONE)); // R7

endmodule

// File: rtl/vtab_engine.sv
module vtab_engine
    import vtab_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PORTS   = 10,
    parameter int VID_W       = 12,
    localparam int IW         = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [VID_W-1:0]     lk_vid,
    output logic                 lk_hit,
    output logic [NUM_PORTS-1:0] lk_mask
);

    scmd_e                  s_cmd;
    logic [IW-1:0]          s_idx;
    logic [VID_W-1:0]       s_vid;
    logic [NUM_PORTS-1:0]   s_mask;
    logic [CMD_PORT_W-1:0]  s_port;
    logic                   q_hit, q_free;
    logic [IW-1:0]          q_hit_idx, q_free_idx;
    logic [NUM_ENTRIES-1:0] valid_vec;
    logic                   ctl_busy;
    logic [2:0]             ctl_op;

    vtab_ctrl #(
        .NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .VID_W(VID_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata), .rd_data(reg_rdata),
        .s_cmd(s_cmd), .s_idx(s_idx), .s_vid(s_vid), .s_mask(s_mask), .s_port(s_port),
        .q_hit(q_hit), .q_hit_idx(q_hit_idx), .q_free(q_free), .q_free_idx(q_free_idx),
        .busy_o(ctl_busy), .op_o(ctl_op)
    );

    vtab_store #(
        .NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .VID_W(VID_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .s_cmd(s_cmd), .s_idx(s_idx), .s_vid(s_vid), .s_mask(s_mask), .s_port(s_port),
        .q_vid(s_vid), .q_hit(q_hit), .q_hit_idx(q_hit_idx),
        .q_free(q_free), .q_free_idx(q_free_idx), .valid_vec(valid_vec),
        .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_mask(lk_mask)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_busy) && $past(ctl_op) == OPC_FLUSH) |-> (valid_vec == '0)); // R4

    AST_MISS_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_mask == '0)); // R11

endmodule

// File: tb/sim_vtab_engine.sv
`timescale 1ns/1ps
module sim_vtab_engine;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] lk_vid = '0;
    logic        lk_hit;
    logic [9:0]  lk_mask;

    int checks = 0;
    int fails  = 0;

    // bench model of the table
    logic        mv   [N];
    logic [11:0] mvid [N];
    logic [9:0]  mmask[N];
    logic        mfull;

    always #4 clk = ~clk;

    vtab_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_mask(lk_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic [2:0] op, input logic go,
                                             input logic [3:0] port, input logic [11:0] vid);
        return {4'b0, vid, 4'b0, port, 3'b0, 1'b0, go, op};
    endfunction

    task automatic bus_wr(input logic a, input logic [31:0] dat);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = dat;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (reg_rdata[3] === 1'b1 && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [3:0] port,
                           input logic [11:0] vid, output int cyc);
        bus_wr(1'b0, cmd_word(op, 1'b1, port, vid));
        wait_idle(cyc);
    endtask

    task automatic model_load(input logic [11:0] vid, input logic [9:0] m);
        int slot;
        slot = -1;
        mfull = 1'b0;
        for (int i = 0; i < N; i++) if (slot < 0 && mv[i] && mvid[i] == vid) slot = i;
        if (slot < 0) for (int i = 0; i < N; i++) if (slot < 0 && !mv[i]) slot = i;
        if (slot < 0) mfull = 1'b1;
        else begin mv[slot] = 1'b1; mvid[slot] = vid; mmask[slot] = m; end
    endtask

    task automatic look(input string req, input logic [11:0] vid,
                        input logic ehit, input logic [9:0] emask);
        lk_vid = vid;
        #1;
        chk(req, {21'b0, lk_hit, lk_mask}, {21'b0, ehit, emask});
    endtask

    task automatic check_table(input string req);
        for (int i = 0; i < N; i++) begin
            if (mv[i]) look(req, mvid[i], 1'b1, mmask[i]);
            else       look(req, mvid[i], 1'b0, 10'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cyc;
        logic [11:0] v;
        logic [9:0]  m;
        for (int i = 0; i < N; i++) begin mv[i] = 0; mvid[i] = 12'(i * 211 + 7); mmask[i] = 0; end
        mfull = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_addr = 1'b0; #1;
        chk("R1 cmd reg", reg_rdata, 32'h0);
        reg_addr = 1'b1; #1;
        chk("R1 data reg", reg_rdata, 32'h0);
        reg_addr = 1'b0;
        look("R1 lookup", 12'h000, 1'b0, 10'h0);
        check_table("R1 table empty");

        // R2 field layout, no start without go
        bus_wr(1'b0, cmd_word(3'd2, 1'b0, 4'd5, 12'hABC) | 32'hF000_F0E0);
        #1;
        chk("R2 cmd readback", reg_rdata, 32'h0ABC_0502);
        @(negedge clk);
        chk("R2 no start", {31'b0, reg_rdata[3]}, 32'h0);

        // R12 data readback
        bus_wr(1'b1, 32'hFFFF_FFFF);
        reg_addr = 1'b1; #1;
        chk("R12 data readback", reg_rdata, 32'h0000_0BFF);
        reg_addr = 1'b0;

        // R5 R3 fill the table, valid bit cleared in half the writes
        for (int i = 0; i < N; i++) begin
            m = 10'((i * 73 + 5));
            bus_wr(1'b1, {20'b0, (i % 2 == 0), 1'b0, m});
            run_cmd(3'd2, 4'd0, mvid[i], cyc);
            model_load(mvid[i], m);
            chk("R3 load busy cycles", cyc, 1);
            chk("R5 full clear", {31'b0, reg_rdata[4]}, 32'h0);
        end
        check_table("R5 R11 lookup after fill");

        // R7 full
        bus_wr(1'b1, 32'h0000_0333);
        run_cmd(3'd2, 4'd0, 12'h999, cyc);
        model_load(12'h999, 10'h333);
        chk("R7 full set", {31'b0, reg_rdata[4]}, {31'b0, mfull});
        chk("R7 full set abs", {31'b0, reg_rdata[4]}, 32'h1);
        look("R7 no insert", 12'h999, 1'b0, 10'h0);
        check_table("R7 table unchanged");

        // R6 overwrite existing
        bus_wr(1'b1, 32'h0000_0155);
        run_cmd(3'd2, 4'd0, mvid[3], cyc);
        model_load(mvid[3], 10'h155);
        chk("R7 full cleared by next go", {31'b0, reg_rdata[4]}, 32'h0);
        chk("R6 model slot", {22'b0, mmask[3]}, 32'h155);
        check_table("R6 overwrite");

        // R8 purge
        run_cmd(3'd3, 4'd0, mvid[5], cyc);
        mv[5] = 1'b0;
        chk("R8 purge cycles", cyc, 1);
        check_table("R8 purge hit");
        run_cmd(3'd3, 4'd0, 12'h999, cyc);
        check_table("R8 purge miss");

        // R5 freed slot reused, then full again
        bus_wr(1'b1, 32'h0000_0201);
        run_cmd(3'd2, 4'd0, 12'h999, cyc);
        look("R5 reuse freed entry", 12'h999, 1'b1, 10'h201);
        mvid[5] = 12'h999; mv[5] = 1'b1; mmask[5] = 10'h201;
        run_cmd(3'd2, 4'd0, 12'h998, cyc);
        chk("R7 full after reuse", {31'b0, reg_rdata[4]}, 32'h1);
        look("R7 extra miss", 12'h998, 1'b0, 10'h0);

        // R9 remove ports
        foreach (mv[k]) if (k < 0) mv[k] = 1'b0;
        for (int p = 0; p < 16; p += 3) begin
            run_cmd(3'd4, 4'(p), 12'h000, cyc);
            chk("R9 drop busy cycles", cyc, N);
            if (p < 10) for (int i = 0; i < N; i++) mmask[i][p] = 1'b0;
            check_table("R9 drop port");
        end

        // R3 no-op and unused opcode
        run_cmd(3'd0, 4'd0, 12'h000, cyc);
        chk("R3 nop cycles", cyc, 1);
        run_cmd(3'd6, 4'd0, 12'h000, cyc);
        chk("R3 unused opcode cycles", cyc, 1);
        check_table("R3 nop no change");

        // R10 R4 writes during flush ignored, flush empties table
        bus_wr(1'b1, 32'h0000_0AAA);
        bus_wr(1'b0, cmd_word(3'd1, 1'b1, 4'd2, 12'h321));
        bus_wr(1'b0, cmd_word(3'd2, 1'b1, 4'd7, 12'h777));
        bus_wr(1'b1, 32'h0000_0055);
        wait_idle(cyc);
        chk("R4 flush length", cyc + 4, N);
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
        check_table("R4 flush empties");
        #1;
        chk("R10 cmd unchanged", reg_rdata, 32'h0321_0201);
        reg_addr = 1'b1; #1;
        chk("R10 data unchanged", reg_rdata, 32'h0000_0AAA);
        reg_addr = 1'b0;
        run_cmd(3'd0, 4'd0, 12'h777, cyc);
        look("R10 second load not run", 12'h777, 1'b0, 10'h0);

        // R11 miss sweep over a range of IDs after flush
        for (int x = 0; x < 4096; x += 257) begin
            v = 12'(x);
            look("R11 miss sweep", v, 1'b0, 10'h0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule